// File: doc/BRIEF.md
# Microcontroller Sleep and Wake Sequencer

This block decides when a small processor core may go to sleep and brings it back in an orderly way. Software loads an 8-bit control register with a sleep-enable flag and a 3-bit mode code. When the core retires its sleep instruction, it sends a single-cycle pulse. The controller then checks that sleep is enabled and that the requested mode is legal for the present clock source. If both hold, it enters the sleep state, holds the core halted and raises one line of a one-hot mode indicator. Other logic uses that indicator to decide which clocks and analog blocks to switch off.

Two events end a sleep: an interrupt request whose per-source enable is set, or a reset request. On the wake event the controller runs a start-up delay of a parameter-set length, then a fixed halt of four cycles. It then drops the halt and gives the core a one-cycle pulse. The pulse either tells the core to take the pending interrupt or sends it to the reset vector. The control register is never cleared by a wake. Register and memory contents outside the block receive no clear or reset from it.

Top module: `slp_ctrl`

## Requirements
- R1: The control register is 8 bits wide. All 8 bits read back as written and all reset to 0. A write takes effect when `reg_we` is high and `reg_addr` equals REG_ADDR. `reg_rdata` shows the register when `reg_addr` equals REG_ADDR and shows 0 for any other address.
- R2: The block enters sleep on a clock edge only when all three of these hold: the block is awake, `sleep_exec` is high, and register bit 7 (sleep enable) is 1. From the next cycle `asleep` and `core_halt` are high. With bit 7 at 0 the pulse has no effect.
- R3: Register bits 6..4 select the mode. During sleep `mode_onehot` has exactly one bit set, chosen by that code: 000 gives bit 0 (idle), 001 gives bit 1 (converter noise reduction), 010 gives bit 2 (power-down), 011 gives bit 3 (power-save), 110 gives bit 4 (standby) and 111 gives bit 5 (extended standby). Outside sleep `mode_onehot` is 0.
- R4: Mode codes 100 and 101 are reserved. A sleep pulse with either code is ignored and the block stays awake.
- R5: Codes 110 and 111 are accepted only while `xtal_clk` is 1. Otherwise the sleep pulse is ignored.
- R6: During sleep, only a request with `irq_req[i]` and `irq_en[i]` both 1 for some source i wakes the block. A request whose enable is 0 leaves it asleep.
- R7: If the wake event is sampled at edge E, `asleep` falls after E. `core_halt` then stays high for STARTUP_CYC + 4 further cycles, and the wake pulse is high in the next cycle, when `core_halt` is already 0.
- R8: When `ext_rst_req` wakes the block, the end pulse is `wake_reset` and `wake_irq` stays low. If an interrupt and a reset request arrive in the same cycle, the reset wins. A reset request that arrives during the start-up or halt phases also turns the ending into `wake_reset`.
- R9: Sleep and wake leave the control register unchanged. An interrupt wake raises no reset pulse.
- R10: `wake_irq` and `wake_reset` are never high together, and each is high for only one cycle per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sleep_exec | input | 1 | One-cycle pulse: core executed its sleep instruction |
| xtal_clk | input | 1 | 1 when the clock source is an external crystal or resonator |
| irq_req | input | NIRQ | Interrupt requests |
| irq_en | input | NIRQ | Per-source interrupt enables |
| ext_rst_req | input | 1 | Reset request that acts as a wake source |
| asleep | output | 1 | High while in the sleep state |
| core_halt | output | 1 | Holds the core during sleep, start-up and halt |
| mode_onehot | output | 6 | One-hot indicator of the active sleep mode |
| wake_irq | output | 1 | One-cycle pulse: resume and service the interrupt |
| wake_reset | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
The two wake sources can fire in the same sleep cycle. The bench provokes this by raising an enabled interrupt and the reset request on the same clock edge. The scoreboard then requires exactly one `wake_reset` pulse, at the cycle given by the start-up plus halt count, and no `wake_irq` pulse at any time. A second overlap pairs an irrelevant event with an active one: a disabled interrupt source is held high during sleep, and the bench checks that the block stays asleep until an enabled source arrives.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int NUM_MODES = 6;
    localparam int HALT_CYC  = 4;

    typedef enum logic [1:0] {
        SEQ_AWAKE,
        SEQ_SLEEP,
        SEQ_START,
        SEQ_HALT
    } seq_state_e;

    typedef enum logic {
        CAUSE_IRQ,
        CAUSE_RST
    } wake_cause_e;

    // Control register image: enable flag on top, mode code below, spare storage at the bottom
    typedef struct packed {
        logic       sen;
        logic [2:0] msel;
        logic [3:0] spare;
    } ctl_reg_t;

    // A mode code is legal unless it is reserved, or it needs a crystal that is absent
    function automatic logic mode_ok(input logic [2:0] code, input logic xtal);
        case (code)
            3'b100, 3'b101: return 1'b0;
            3'b110, 3'b111: return xtal;
            default:        return 1'b1;
        endcase
    endfunction

    function automatic logic [NUM_MODES-1:0] mode_bit(input logic [2:0] code);
        logic [NUM_MODES-1:0] v;
        v = '0;
        case (code)
            3'b000: v[0] = 1'b1;
            3'b001: v[1] = 1'b1;
            3'b010: v[2] = 1'b1;
            3'b011: v[3] = 1'b1;
            3'b110: v[4] = 1'b1;
            3'b111: v[5] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/slp_ctlreg.sv
module slp_ctlreg
    import slp_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int REG_ADDR = 'h15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output ctl_reg_t          ctl
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    ctl_reg_t ctl_q;
    logic     hit;

    assign hit = (addr == MY_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (we && hit) begin
            ctl_q <= ctl_reg_t'(wdata);
        end
    end

    assign ctl   = ctl_q;
    assign rdata = hit ? 8'(ctl_q) : 8'h00;

    // R1
    reg_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && hit) |=> (8'(ctl) == $past(wdata)));

    // R1
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we && !$past(rst)) |=> $stable(ctl));

endmodule

// File: rtl/slp_mode_dec.sv
module slp_mode_dec
    import slp_pkg::*;
(
    input  logic [2:0]           code,
    input  logic                 xtal,
    output logic                 legal,
    output logic [NUM_MODES-1:0] onehot
);

    always_comb begin
        legal  = mode_ok(code, xtal);
        onehot = legal ? mode_bit(code) : '0;
    end

endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
    import slp_pkg::*;
#(
    parameter int STARTUP_CYC = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep_go,
    input  logic [NUM_MODES-1:0] mode_in,
    input  logic                 irq_hit,
    input  logic                 rst_hit,
    output logic                 asleep,
    output logic                 core_halt,
    output logic [NUM_MODES-1:0] mode_out,
    output logic                 wake_irq,
    output logic                 wake_reset
);

    localparam int MAXC  = (STARTUP_CYC > HALT_CYC) ? STARTUP_CYC : HALT_CYC;
    localparam int CNT_W = $clog2(MAXC) + 1;
    localparam logic [CNT_W-1:0] START_LD = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] HALT_LD  = CNT_W'(HALT_CYC - 1);

    seq_state_e           st;
    wake_cause_e          cause;
    logic [CNT_W-1:0]     cnt;
    logic [NUM_MODES-1:0] mode_q;
    logic                 rst_seen;
    logic                 pulse_irq, pulse_rst;

    assign rst_seen = (cause == CAUSE_RST) || rst_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SEQ_AWAKE;
            cause     <= CAUSE_IRQ;
            cnt       <= '0;
            mode_q    <= '0;
            pulse_irq <= 1'b0;
            pulse_rst <= 1'b0;
        end else begin
            pulse_irq <= 1'b0;
            pulse_rst <= 1'b0;
            case (st)
                SEQ_AWAKE: begin
                    if (sleep_go) begin
                        st     <= SEQ_SLEEP;
                        mode_q <= mode_in;
                    end
                end
                SEQ_SLEEP: begin
                    if (rst_hit || irq_hit) begin
                        st     <= SEQ_START;
                        cnt    <= START_LD;
                        mode_q <= '0;
                        cause  <= rst_hit ? CAUSE_RST : CAUSE_IRQ;
                    end
                end
                SEQ_START: begin
                    if (rst_hit) cause <= CAUSE_RST;
                    if (cnt == '0) begin
                        st  <= SEQ_HALT;
                        cnt <= HALT_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (rst_hit) cause <= CAUSE_RST;
                    if (cnt == '0) begin
                        st        <= SEQ_AWAKE;
                        pulse_rst <= rst_seen;
                        pulse_irq <= !rst_seen;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign asleep     = (st == SEQ_SLEEP);
    assign core_halt  = (st != SEQ_AWAKE);
    assign mode_out   = mode_q;
    assign wake_irq   = pulse_irq;
    assign wake_reset = pulse_rst;

    // R2
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_AWAKE && sleep_go) |=> asleep);

    // R7
    wake_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_halt) |-> (wake_irq || wake_reset));

    // R7
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st == SEQ_HALT) |-> ($past(st) == SEQ_START && cnt == HALT_LD));

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_irq || wake_reset) |=> !(wake_irq || wake_reset));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wake_irq && wake_reset));

    // R8
    rst_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep && rst_hit) |=> (st == SEQ_START && cause == CAUSE_RST));

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int REG_ADDR    = 'h15,
    parameter int NIRQ        = 4,
    parameter int STARTUP_CYC = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 sleep_exec,
    input  logic                 xtal_clk,
    input  logic [NIRQ-1:0]      irq_req,
    input  logic [NIRQ-1:0]      irq_en,
    input  logic                 ext_rst_req,
    output logic                 asleep,
    output logic                 core_halt,
    output logic [NUM_MODES-1:0] mode_onehot,
    output logic                 wake_irq,
    output logic                 wake_reset
);

    ctl_reg_t             ctl;
    logic                 legal;
    logic [NUM_MODES-1:0] dec_onehot;
    logic                 sleep_go;
    logic                 irq_hit;

    slp_ctlreg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctl   (ctl)
    );

    slp_mode_dec u_dec (
        .code   (ctl.msel),
        .xtal   (xtal_clk),
        .legal  (legal),
        .onehot (dec_onehot)
    );

    assign sleep_go = sleep_exec && ctl.sen && legal;
    assign irq_hit  = |(irq_req & irq_en);

    slp_wake_seq #(
        .STARTUP_CYC (STARTUP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sleep_go   (sleep_go),
        .mode_in    (dec_onehot),
        .irq_hit    (irq_hit),
        .rst_hit    (ext_rst_req),
        .asleep     (asleep),
        .core_halt  (core_halt),
        .mode_out   (mode_onehot),
        .wake_irq   (wake_irq),
        .wake_reset (wake_reset)
    );

    // R3
    mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        asleep |-> ($countones(mode_onehot) == 1));

    // R3
    mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !asleep |-> (mode_onehot == '0));

    // R4
    reserved_rej_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_halt && sleep_exec && (ctl.msel == 3'b100 || ctl.msel == 3'b101)) |=> !asleep);

    // R5
    standby_rej_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_halt && sleep_exec && !xtal_clk && ctl.msel[2:1] == 2'b11) |=> !asleep);

    // R6
    no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep && !irq_hit && !ext_rst_req) |=> asleep);

endmodule

// File: tb/slp_ctrl_tb.sv
module slp_ctrl_tb;

    localparam int ADDR_W   = 6;
    localparam int REG_ADDR = 'h15;
    localparam int NIRQ     = 4;
    localparam int SCYC     = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [7:0]        reg_wdata;
    logic [7:0]        reg_rdata;
    logic              sleep_exec;
    logic              xtal_clk;
    logic [NIRQ-1:0]   irq_req;
    logic [NIRQ-1:0]   irq_en;
    logic              ext_rst_req;
    logic              asleep;
    logic              core_halt;
    logic [5:0]        mode_onehot;
    logic              wake_irq;
    logic              wake_reset;

    slp_ctrl #(
        .ADDR_W      (ADDR_W),
        .REG_ADDR    (REG_ADDR),
        .NIRQ        (NIRQ),
        .STARTUP_CYC (SCYC)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .sleep_exec  (sleep_exec),
        .xtal_clk    (xtal_clk),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .ext_rst_req (ext_rst_req),
        .asleep      (asleep),
        .core_halt   (core_halt),
        .mode_onehot (mode_onehot),
        .wake_irq    (wake_irq),
        .wake_reset  (wake_reset)
    );

    always #5 clk = ~clk;

    int cyc    = 0;
    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit is_rst;
        int when;
    } exp_t;

    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every wake pulse must match the oldest expected item
    always @(negedge clk) begin
        if (!rst && (wake_irq || wake_reset)) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10 unexpected wake pulse", {wake_reset, wake_irq}, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(wake_irq != wake_reset, "R10 single pulse kind", {wake_reset, wake_irq}, e.is_rst ? 2 : 1);
                check(wake_reset == e.is_rst, "R8 wake cause", wake_reset, e.is_rst);
                check(cyc == e.when, "R7 wake pulse cycle", cyc, e.when);
                check(core_halt == 1'b0, "R7 halt released with pulse", core_halt, 0);
            end
        end
    end

    task automatic write_reg(input logic [7:0] d);
        reg_we    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_exec = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
    endtask

    // Drive a wake event, push the expected pulse, and watch core_halt across the wake
    task automatic wake(input bit use_irq, input bit use_rst);
        exp_t e;
        bit   held;
        e.is_rst = use_rst;
        e.when   = cyc + SCYC + 5;
        sbq.push_back(e);
        if (use_irq) irq_req = 4'b0001;
        if (use_rst) ext_rst_req = 1'b1;
        @(negedge clk);
        irq_req     = '0;
        ext_rst_req = 1'b0;
        held = 1'b1;
        if (asleep) held = 1'b0;
        for (int i = 1; i < SCYC + 4; i++) begin
            if (!core_halt || asleep || mode_onehot != 0) held = 1'b0;
            @(negedge clk);
        end
        if (!core_halt) held = 1'b0;
        check(held, "R7 halt held through start-up and halt", held, 1);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst         = 1'b1;
        reg_we      = 1'b0;
        reg_addr    = ADDR_W'(REG_ADDR);
        reg_wdata   = '0;
        sleep_exec  = 1'b0;
        xtal_clk    = 1'b1;
        irq_req     = '0;
        irq_en      = 4'b1011;
        ext_rst_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
        check(!asleep && !core_halt && mode_onehot == 0, "R2 awake after reset",
              {asleep, core_halt, mode_onehot}, 0);

        // R1 read/write of all bits and address decode
        write_reg(8'hA5);
        check(reg_rdata == 8'hA5, "R1 readback", reg_rdata, 8'hA5);
        reg_addr = ADDR_W'(REG_ADDR + 1);
        #1;
        check(reg_rdata == 8'h00, "R1 other address reads zero", reg_rdata, 0);
        write_reg(8'h3C);
        reg_addr = ADDR_W'(REG_ADDR);
        #1;
        check(reg_rdata == 8'hA5, "R1 write elsewhere ignored", reg_rdata, 8'hA5);

        // R2 enable bit clear: pulse has no effect
        write_reg(8'h20);
        pulse_sleep();
        check(!asleep && !core_halt, "R2 sleep without enable", asleep, 0);

        // R3 R4 R5 every mode code under both clock sources, each legal one woken by interrupt
        for (int x = 0; x < 2; x++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] v;
                bit         legal;
                int         idx;
                xtal_clk = x[0];
                v = {1'b1, c[2:0], 4'b0110};
                legal = !(c == 4 || c == 5) && !(c >= 6 && x == 0);
                idx = (c < 4) ? c : c - 2;
                write_reg(v);
                pulse_sleep();
                if (!legal) begin
                    check(!asleep && !core_halt,
                          (c == 4 || c == 5) ? "R4 reserved code ignored" : "R5 standby needs crystal",
                          asleep, 0);
                end else begin
                    check(asleep && core_halt, "R2 sleep entered", {asleep, core_halt}, 3);
                    check(mode_onehot == 6'(1 << idx), "R3 mode indicator", mode_onehot, 1 << idx);
                    wake(1'b1, 1'b0);
                    check(reg_rdata == v, "R9 register kept over wake", reg_rdata, v);
                    check(mode_onehot == 0, "R3 indicator cleared awake", mode_onehot, 0);
                end
            end
        end

        // R6 disabled source does not wake
        xtal_clk = 1'b1;
        write_reg(8'hA0);
        pulse_sleep();
        irq_req = 4'b0100;
        repeat (4) @(negedge clk);
        check(asleep, "R6 disabled interrupt ignored", asleep, 1);
        irq_req = '0;
        wake(1'b1, 1'b0);

        // R8 reset request wakes toward the reset vector
        pulse_sleep();
        check(asleep, "R2 sleep again", asleep, 1);
        wake(1'b0, 1'b1);
        check(reg_rdata == 8'hA0, "R9 register kept over reset wake", reg_rdata, 8'hA0);

        // R8 interrupt and reset in the same cycle: reset wins
        pulse_sleep();
        wake(1'b1, 1'b1);

        // R8 reset arriving in the middle of start-up upgrades the cause
        pulse_sleep();
        begin
            exp_t e;
            e.is_rst = 1'b1;
            e.when   = cyc + SCYC + 5;
            sbq.push_back(e);
            irq_req = 4'b0001;
            @(negedge clk);
            irq_req = '0;
            @(negedge clk);
            ext_rst_req = 1'b1;
            @(negedge clk);
            ext_rst_req = 1'b0;
            repeat (SCYC + 4) @(negedge clk);
        end

        check(sbq.size() == 0, "R7 all expected wakes seen", sbq.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule